// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Access Check

This block caches virtual-to-physical page translations for a pipeline stage. A lookup presents a virtual page number, a page offset, the access type (read or write) and the privilege level (user or kernel). Every stored tag is compared in parallel. On a hit the block returns the physical address, which is the stored physical page number followed by the offset as given. In the same cycle it checks the access against the permission bits of the entry. A denied access raises a fault and returns no address. On a miss the block raises a walk request carrying the virtual page number, so that an external table walker can fetch the translation.

The walker hands back the translation on a refill port. The block writes it into the entry that already holds that page, if there is one. Otherwise it writes it into the entry chosen by the replacement policy. A parameter selects the policy: a rotating first-in first-out pointer or a free-running pseudo-random sequence. A flush input invalidates the whole buffer in one cycle.

Each entry keeps a modified flag. The first permitted write to a page sets that flag, so that software can later find the pages it has to write back.

Top module: `tlb_top`

## Requirements
- R1: After reset every entry is invalid, so any lookup misses.
- R2: When a lookup (`lk_valid`=1) matches a valid entry, `lk_hit`=1 in that same cycle. If the access is permitted, `lk_paddr` equals {stored physical page, `lk_off`}, with the offset in the low OFF_W bits unchanged.
- R3: A lookup that matches no valid entry gives `lk_miss`=1, `walk_req`=1, `walk_vpn`=`lk_vpn` and `lk_paddr`=0. With `lk_valid`=0, `lk_hit` and `lk_miss` are both 0.
- R4: A refill accepted in cycle t is seen by lookups from cycle t+1 on. A lookup in cycle t itself sees the old contents.
- R5: A read needs the entry's read bit, and a write needs its write bit. A user-mode access (`lk_user`=1) also needs the entry's user bit, while a kernel-mode access ignores that bit. A denied hit gives `lk_hit`=1, `lk_fault`=1 and `lk_paddr`=0.
- R6: On a hit, `lk_dirty` shows the stored modified flag. A permitted write hit sets that flag, and lookups see the change from the next cycle on. A faulting write leaves the flag unchanged.
- R7: `flush` invalidates every entry in one cycle, so lookups from the next cycle on miss.
- R8: With REPL_RANDOM=0, refills of new pages go to entries in rotating order. Once all ENTRIES entries are full, the next new page evicts the oldest one, and the one after that evicts the next oldest.
- R9: A refill whose page is already present rewrites that entry in place, with the new physical page and permissions. It does not advance the replacement order, so no tag is ever stored twice.
- R10: When `flush` and `fill_valid` are both high in the same cycle, the flush wins and the refill is dropped.
- R11: With REPL_RANDOM=1 the victim entry comes from a free-running pseudo-random register, reduced to an index below ENTRIES. Hit, fault and address results stay the same as in R2 to R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vpn | input | VPN_W | Virtual page number of the lookup |
| lk_off | input | OFF_W | Page offset, passed through unchanged |
| lk_write | input | 1 | 1 = write access, 0 = read access |
| lk_user | input | 1 | 1 = user mode, 0 = kernel mode |
| lk_hit | output | 1 | Lookup matched a valid entry |
| lk_miss | output | 1 | Lookup matched no entry |
| lk_fault | output | 1 | Hit denied by the permission check |
| lk_dirty | output | 1 | Modified flag of the matching entry |
| lk_paddr | output | PPN_W+OFF_W | Physical address on a permitted hit, else 0 |
| walk_req | output | 1 | Request to the table walker |
| walk_vpn | output | VPN_W | Page the walker must resolve |
| fill_valid | input | 1 | Refill from the walker this cycle |
| fill_vpn | input | VPN_W | Virtual page being installed |
| fill_ppn | input | PPN_W | Physical page being installed |
| fill_rd | input | 1 | Read permission of the new entry |
| fill_wr | input | 1 | Write permission of the new entry |
| fill_usr | input | 1 | User-mode access allowed |
| fill_dirty | input | 1 | Initial modified flag |
| flush | input | 1 | Invalidate all entries |

## Verification
The lookup results (hit, miss, fault, modified flag, address and walk request) are combinational. They are due in the same cycle in which the lookup is presented. Refills, flushes and modified-flag updates change state at the rising edge, so their effect shows up on the first lookup after that edge. The driver applies every operation at the falling edge and pushes the expected outcome into a queue. The monitor checks the outputs a quarter period later, still inside that cycle. Tests of a state change therefore always use a later lookup, which the driver places at least one edge after the change.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  // Permission bits kept with every entry.
  typedef struct packed {
    logic rd;
    logic wr;
    logic usr;
  } tlb_perm_t;

  // Returns 1 when an access of the given kind is allowed by perm.
  function automatic logic tlb_access_ok(input tlb_perm_t perm,
                                         input logic is_write,
                                         input logic user_mode);
    logic kind_ok;
    kind_ok = is_write ? perm.wr : perm.rd;
    return kind_ok & (~user_mode | perm.usr);
  endfunction

endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic [VPN_W-1:0]   tags [ENTRIES],
  input  logic [ENTRIES-1:0] vld,
  input  logic [VPN_W-1:0]   key,
  output logic [ENTRIES-1:0] match,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);

  // One comparator per entry, all in parallel.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = vld[g] & (tags[g] == key);
  end

  assign any = |match;

  // At most one bit of match is set, so OR-ing the indices encodes it.
  always_comb begin
    idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) idx = idx | IDX_W'(i);
    end
  end

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES     = 64,
  parameter int IDX_W       = $clog2(ENTRIES),
  parameter bit REPL_RANDOM = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             clr,
  output logic [IDX_W-1:0] victim
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  if (REPL_RANDOM) begin : g_rand
    localparam int          LW   = 16;
    localparam logic [LW-1:0] TAPS = 16'hB400;
    localparam logic [LW-1:0] SEED = 16'hACE1;

    logic [LW-1:0]  lfsr_q, lfsr_d;
    logic [IDX_W:0] raw;
    logic           unused_ctl;

    assign unused_ctl = adv ^ clr;

    always_comb begin
      lfsr_d = {1'b0, lfsr_q[LW-1:1]} ^ (lfsr_q[0] ? TAPS : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lfsr_q <= SEED;
      else        lfsr_q <= lfsr_d;
    end

    // Fold the low bits back into range when ENTRIES is not a power of two.
    assign raw    = {1'b0, lfsr_q[IDX_W-1:0]};
    assign victim = (raw >= (IDX_W+1)'(ENTRIES)) ? IDX_W'(raw - (IDX_W+1)'(ENTRIES))
                                                 : raw[IDX_W-1:0];
  end else begin : g_fifo
    logic [IDX_W-1:0] ptr_q, ptr_d;
    logic             ptr_en;

    assign ptr_en = adv | clr;

    always_comb begin
      if (clr)               ptr_d = '0;
      else if (ptr_q == LAST) ptr_d = '0;
      else                   ptr_d = ptr_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ptr_q <= '0;
      else if (ptr_en) ptr_q <= ptr_d;
    end

    assign victim = ptr_q;
  end

endmodule

// File: rtl/tlb_top.sv
module tlb_top
  import tlb_pkg::*;
#(
  parameter int ENTRIES     = 64,
  parameter int VPN_W       = 20,
  parameter int PPN_W       = 20,
  parameter int OFF_W       = 12,
  parameter bit REPL_RANDOM = 1'b0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lk_valid,
  input  logic [VPN_W-1:0]       lk_vpn,
  input  logic [OFF_W-1:0]       lk_off,
  input  logic                   lk_write,
  input  logic                   lk_user,
  output logic                   lk_hit,
  output logic                   lk_miss,
  output logic                   lk_fault,
  output logic                   lk_dirty,
  output logic [PPN_W+OFF_W-1:0] lk_paddr,
  output logic                   walk_req,
  output logic [VPN_W-1:0]       walk_vpn,
  input  logic                   fill_valid,
  input  logic [VPN_W-1:0]       fill_vpn,
  input  logic [PPN_W-1:0]       fill_ppn,
  input  logic                   fill_rd,
  input  logic                   fill_wr,
  input  logic                   fill_usr,
  input  logic                   fill_dirty,
  input  logic                   flush
);

  localparam int IDX_W = $clog2(ENTRIES);

  // Entry storage, gathered from the per-entry registers below.
  logic [VPN_W-1:0]   tag_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q, dty_q;
  tlb_perm_t          perm_q [ENTRIES];

  // Lookup-side match.
  logic [ENTRIES-1:0] lk_match;
  logic               lk_any;
  logic [IDX_W-1:0]   lk_idx;

  tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .IDX_W(IDX_W)) u_cam_lk (
    .tags (tag_q),
    .vld  (vld_q),
    .key  (lk_vpn),
    .match(lk_match),
    .any  (lk_any),
    .idx  (lk_idx)
  );

  // Refill-side match, used to find an entry that already holds the page.
  logic [ENTRIES-1:0] fl_match;
  logic               fl_any;
  logic [IDX_W-1:0]   fl_idx;

  tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .IDX_W(IDX_W)) u_cam_fl (
    .tags (tag_q),
    .vld  (vld_q),
    .key  (fill_vpn),
    .match(fl_match),
    .any  (fl_any),
    .idx  (fl_idx)
  );

  logic unused_match;
  assign unused_match = ^{lk_match, fl_match};

  // Replacement.
  logic             fill_go, fill_new;
  logic [IDX_W-1:0] vic_idx, wr_idx;

  assign fill_go  = fill_valid & ~flush;
  assign fill_new = fill_go & ~fl_any;
  assign wr_idx   = fl_any ? fl_idx : vic_idx;

  tlb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .REPL_RANDOM(REPL_RANDOM)) u_victim (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (fill_new),
    .clr   (flush),
    .victim(vic_idx)
  );

  // Lookup result.
  tlb_perm_t        sel_perm;
  logic [PPN_W-1:0] sel_ppn;
  logic             sel_dty;
  logic             lk_ok;
  logic             dset;

  always_comb begin
    sel_perm = perm_q[lk_idx];
    sel_ppn  = ppn_q[lk_idx];
    sel_dty  = dty_q[lk_idx];
    lk_ok    = tlb_access_ok(sel_perm, lk_write, lk_user);
  end

  assign lk_hit   = lk_valid & lk_any;
  assign lk_miss  = lk_valid & ~lk_any;
  assign lk_fault = lk_hit & ~lk_ok;
  assign lk_dirty = lk_hit & sel_dty;
  assign lk_paddr = (lk_hit & lk_ok) ? {sel_ppn, lk_off} : '0;
  assign walk_req = lk_miss;
  assign walk_vpn = lk_miss ? lk_vpn : '0;

  // A permitted write to a clean page marks it modified.
  assign dset = lk_hit & lk_ok & lk_write & ~sel_dty & ~flush;

  // Per-entry state.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic             we, dset_g;
    logic             vld_r, vld_d;
    logic             dty_r, dty_d;
    tlb_perm_t        perm_r, perm_d;
    logic             flg_en;
    logic [VPN_W-1:0] tag_r;
    logic [PPN_W-1:0] ppn_r;

    assign we     = fill_go & (wr_idx == IDX_W'(g));
    assign dset_g = dset & (lk_idx == IDX_W'(g));
    assign flg_en = we | dset_g;

    always_comb begin
      vld_d  = vld_r;
      dty_d  = dty_r;
      perm_d = perm_r;
      if (we) begin
        vld_d  = 1'b1;
        dty_d  = fill_dirty;
        perm_d = '{rd: fill_rd, wr: fill_wr, usr: fill_usr};
      end else if (dset_g) begin
        dty_d = 1'b1;
      end
      if (flush) vld_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_r <= 1'b0;
      else        vld_r <= vld_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dty_r  <= 1'b0;
        perm_r <= '0;
      end else if (flg_en) begin
        dty_r  <= dty_d;
        perm_r <= perm_d;
      end
    end

    // Datapath storage, qualified by the valid bit, needs no reset.
    always_ff @(posedge clk) begin
      if (we) begin
        tag_r <= fill_vpn;
        ppn_r <= fill_ppn;
      end
    end

    assign vld_q[g]  = vld_r;
    assign dty_q[g]  = dty_r;
    assign perm_q[g] = perm_r;
    assign tag_q[g]  = tag_r;
    assign ppn_q[g]  = ppn_r;
  end

endmodule

// File: rtl/tlb_top_chk.sv
module tlb_top_chk #(
  parameter int VPN_W = 20,
  parameter int PPN_W = 20,
  parameter int OFF_W = 12
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   lk_valid,
  input logic [VPN_W-1:0]       lk_vpn,
  input logic [OFF_W-1:0]       lk_off,
  input logic                   lk_write,
  input logic                   lk_hit,
  input logic                   lk_miss,
  input logic                   lk_fault,
  input logic                   lk_dirty,
  input logic [PPN_W+OFF_W-1:0] lk_paddr,
  input logic                   fill_valid,
  input logic [VPN_W-1:0]       fill_vpn,
  input logic                   flush
);

  AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> (lk_hit ^ lk_miss)); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!lk_hit && !lk_miss)); // R3

  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && !lk_fault) |-> (lk_paddr[OFF_W-1:0] == lk_off)); // R2

  AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |-> (lk_hit && lk_paddr == '0)); // R5

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !lk_hit); // R7

  AST_FILL_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !flush) |=> (!(lk_valid && lk_vpn == $past(fill_vpn)) || lk_hit)); // R4

  AST_DIRTY_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && !lk_fault && lk_write && !flush && !fill_valid)
      |=> (!(lk_valid && lk_vpn == $past(lk_vpn)) || lk_dirty)); // R6

endmodule

bind tlb_top tlb_top_chk #(.VPN_W(VPN_W), .PPN_W(PPN_W), .OFF_W(OFF_W)) u_chk (.*);

// File: tb/tlb_top_test.sv
module tlb_top_test;

  localparam int CLK_PERIOD = 10;
  localparam int VW = 20;
  localparam int PW = 20;
  localparam int OW = 12;
  localparam int MAX_CYC = 20000;

  logic clk, rst_n;
  logic lk_valid, lk_write, lk_user;
  logic [VW-1:0] lk_vpn;
  logic [OW-1:0] lk_off;
  logic fill_valid, fill_rd, fill_wr, fill_usr, fill_dirty, flush;
  logic [VW-1:0] fill_vpn;
  logic [PW-1:0] fill_ppn;

  logic lk_hit, lk_miss, lk_fault, lk_dirty, walk_req;
  logic [PW+OW-1:0] lk_paddr;
  logic [VW-1:0] walk_vpn;

  logic r_hit, r_miss, r_fault, r_dirty, r_walk;
  logic [PW+OW-1:0] r_paddr;
  logic [VW-1:0] r_wvpn;

  tlb_top uut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_off(lk_off),
    .lk_write(lk_write), .lk_user(lk_user), .lk_hit(lk_hit), .lk_miss(lk_miss),
    .lk_fault(lk_fault), .lk_dirty(lk_dirty), .lk_paddr(lk_paddr), .walk_req(walk_req),
    .walk_vpn(walk_vpn), .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_rd(fill_rd), .fill_wr(fill_wr), .fill_usr(fill_usr), .fill_dirty(fill_dirty),
    .flush(flush));

  // R11: second copy with pseudo-random replacement and fewer entries.
  tlb_top #(.ENTRIES(32), .REPL_RANDOM(1'b1)) uut_rand (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_off(lk_off),
    .lk_write(lk_write), .lk_user(lk_user), .lk_hit(r_hit), .lk_miss(r_miss),
    .lk_fault(r_fault), .lk_dirty(r_dirty), .lk_paddr(r_paddr), .walk_req(r_walk),
    .walk_vpn(r_wvpn), .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_rd(fill_rd), .fill_wr(fill_wr), .fill_usr(fill_usr), .fill_dirty(fill_dirty),
    .flush(flush));

  typedef struct {
    logic [VW-1:0] vpn;
    logic [OW-1:0] off;
    logic          hit;
    logic          fault;
    logic [PW-1:0] ppn;
    logic          dirty;
    logic          rnd;
    string         req;
  } exp_t;

  exp_t sb[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   rnd_on = 1'b0;
  bit   done = 1'b0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    lk_valid = 0; lk_vpn = '0; lk_off = '0; lk_write = 0; lk_user = 0;
    fill_valid = 0; fill_vpn = '0; fill_ppn = '0;
    fill_rd = 0; fill_wr = 0; fill_usr = 0; fill_dirty = 0; flush = 0;
  endtask

  task automatic drive_look(input logic [VW-1:0] vpn, input logic [OW-1:0] off,
                            input logic wr, input logic usr, input logic hit,
                            input logic fault, input logic [PW-1:0] ppn,
                            input logic dirty, input string req);
    exp_t e;
    lk_valid = 1; lk_vpn = vpn; lk_off = off; lk_write = wr; lk_user = usr;
    e.vpn = vpn; e.off = off; e.hit = hit; e.fault = fault; e.ppn = ppn;
    e.dirty = dirty; e.rnd = rnd_on; e.req = req;
    sb.push_back(e);
  endtask

  task automatic drive_fill(input logic [VW-1:0] vpn, input logic [PW-1:0] ppn,
                            input logic rd, input logic wr, input logic usr, input logic d);
    fill_valid = 1; fill_vpn = vpn; fill_ppn = ppn;
    fill_rd = rd; fill_wr = wr; fill_usr = usr; fill_dirty = d;
  endtask

  task automatic look(input logic [VW-1:0] vpn, input logic [OW-1:0] off,
                      input logic wr, input logic usr, input logic hit,
                      input logic fault, input logic [PW-1:0] ppn,
                      input logic dirty, input string req);
    @(negedge clk);
    idle_inputs();
    drive_look(vpn, off, wr, usr, hit, fault, ppn, dirty, req);
  endtask

  task automatic fill(input logic [VW-1:0] vpn, input logic [PW-1:0] ppn,
                      input logic rd, input logic wr, input logic usr, input logic d);
    @(negedge clk);
    idle_inputs();
    drive_fill(vpn, ppn, rd, wr, usr, d);
  endtask

  task automatic do_flush();
    @(negedge clk);
    idle_inputs();
    flush = 1;
  endtask

  // Monitor: compares every queued expectation inside its own cycle.
  initial begin
    exp_t e;
    logic [PW+OW-1:0] pa;
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      while (sb.size() > 0) begin
        e  = sb.pop_front();
        pa = (e.hit && !e.fault) ? {e.ppn, e.off} : '0;
        chk(lk_hit == e.hit, e.req, "hit", 64'(lk_hit), 64'(e.hit));
        chk(lk_miss == !e.hit, e.req, "miss", 64'(lk_miss), 64'(!e.hit));
        chk(lk_fault == e.fault, e.req, "fault", 64'(lk_fault), 64'(e.fault));
        chk(lk_paddr == pa, e.req, "paddr", 64'(lk_paddr), 64'(pa));
        if (e.hit) begin
          chk(lk_dirty == e.dirty, e.req, "dirty", 64'(lk_dirty), 64'(e.dirty));
        end else begin
          chk(walk_req == 1'b1, e.req, "walk_req", 64'(walk_req), 64'd1);
          chk(walk_vpn == e.vpn, e.req, "walk_vpn", 64'(walk_vpn), 64'(e.vpn));
        end
        if (e.rnd) begin
          chk(r_hit == e.hit, {e.req, "/R11"}, "hit", 64'(r_hit), 64'(e.hit));
          chk(r_fault == e.fault, {e.req, "/R11"}, "fault", 64'(r_fault), 64'(e.fault));
          chk(r_paddr == pa, {e.req, "/R11"}, "paddr", 64'(r_paddr), 64'(pa));
        end
      end
    end
  end

  // Watchdog.
  initial begin
    repeat (MAX_CYC) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", MAX_CYC, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  localparam logic [VW-1:0] VA = 20'h00010, VB = 20'h00020, VC = 20'h00030, VD = 20'h00040;
  localparam logic [PW-1:0] P1 = 20'h0ABCD, P2 = 20'h01234, P3 = 20'h05555;

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rnd_on = 1'b1;

    // R1: empty after reset
    look(20'h5, 12'h000, 0, 1, 0, 0, '0, 0, "R1");
    // R4: refill and lookup in the same cycle sees old contents
    @(negedge clk);
    idle_inputs();
    drive_fill(VA, P1, 1, 1, 1, 0);
    drive_look(VA, 12'h123, 0, 1, 0, 0, '0, 0, "R4");
    // R2: hit with offset passed through
    look(VA, 12'h123, 0, 1, 1, 0, P1, 0, "R2");
    // R6: permitted write reports old flag, then the flag is set
    look(VA, 12'hFFF, 1, 1, 1, 0, P1, 0, "R6");
    look(VA, 12'h000, 0, 0, 1, 0, P1, 1, "R6");
    // R5: read-only, kernel-only page
    fill(VB, P2, 1, 0, 0, 0);
    look(VB, 12'h010, 1, 0, 1, 1, P2, 0, "R5");
    look(VB, 12'h010, 0, 1, 1, 1, P2, 0, "R5");
    look(VB, 12'h456, 0, 0, 1, 0, P2, 0, "R5");
    look(VB, 12'h456, 0, 0, 1, 0, P2, 0, "R6");
    // R5: write-only user page, installed already modified
    fill(VC, P3, 0, 1, 1, 1);
    look(VC, 12'h001, 0, 1, 1, 1, P3, 1, "R5");
    look(VC, 12'h0AB, 1, 1, 1, 0, P3, 1, "R5");
    // R3: plain miss
    look(20'hFFFFF, 12'h777, 0, 0, 0, 0, '0, 0, "R3");
    // R7 and R10: flush together with a refill
    @(negedge clk);
    idle_inputs();
    flush = 1;
    drive_fill(VD, P1, 1, 1, 1, 0);
    look(VA, 12'h000, 0, 0, 0, 0, '0, 0, "R7");
    look(VB, 12'h000, 0, 0, 0, 0, '0, 0, "R7");
    look(VD, 12'h000, 0, 0, 0, 0, '0, 0, "R10");

    // R8 and R9: rotating order on the 64-entry instance
    rnd_on = 1'b0;
    fill(20'h00100, 20'h00000, 1, 1, 1, 0);
    fill(20'h00100, 20'h00777, 1, 1, 1, 0);
    for (int i = 1; i < 64; i++) fill(VW'(20'h00100 + i), PW'(20'h00200 + i), 1, 1, 1, 0);
    look(20'h00100, 12'h004, 0, 1, 1, 0, 20'h00777, 0, "R9");
    look(20'h0013F, 12'h008, 0, 1, 1, 0, 20'h0023F, 0, "R8");
    fill(20'h00140, 20'h00240, 1, 1, 1, 0);
    look(20'h00100, 12'h004, 0, 1, 0, 0, '0, 0, "R8");
    look(20'h00101, 12'h004, 0, 1, 1, 0, 20'h00201, 0, "R8");
    look(20'h00140, 12'h004, 0, 1, 1, 0, 20'h00240, 0, "R8");
    fill(20'h00141, 20'h00241, 1, 1, 1, 0);
    look(20'h00101, 12'h004, 0, 1, 0, 0, '0, 0, "R8");
    look(20'h00102, 12'h004, 0, 1, 1, 0, 20'h00202, 0, "R8");

    // R11: install and hit on both instances after a flush
    do_flush();
    rnd_on = 1'b1;
    fill(20'h00300, P2, 1, 1, 1, 0);
    look(20'h00300, 12'h0CD, 0, 1, 1, 0, P2, 0, "R11");
    look(20'h00301, 12'h0CD, 0, 1, 0, 0, '0, 0, "R11");

    @(negedge clk);
    idle_inputs();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule